// File: doc/BRIEF.md
# Serial Write-Only Configuration Port

This block is the configuration slave of a multi-channel converter. An external controller lowers an active-low select line, toggles a serial clock and shifts one bit per rising edge into the block. Each 24-bit frame carries an 8-bit register address followed by 16 bits of data, most significant bit first. The frame is committed to an internal register file on its 24th rising edge. The register file drives the converter's control fields as parallel outputs, and nothing can be read back.

A small state machine on the serial clock tracks the frame. It has three states. S_ADDR collects the eight address bits and moves to S_DATA on the eighth edge. S_DATA collects the sixteen data bits and, on the 24th edge, writes and moves to S_SKIP. S_SKIP discards every further bit until the select line is released. Releasing the select line asynchronously returns the machine to S_ADDR with a cleared counter. The control fields live in the serial-clock domain and reach the system clock domain through a chain of synchronizing flip-flops. The chain is two stages deep by default.

Two mechanisms return every field to its default, which is zero for every field. One is an asynchronous active-low reset pin. The other is a software reset: a write to address 0x00 with data bit 0 set. The software reset bit is not kept, so it clears itself.

Top module: `spi_cfg_slave`

## Requirements
- R1: While `rst_n` is low, every output field is zero. A reset pulse of 20 ns or longer, applied at any time, returns every field to zero.
- R2: While `spi_csn` is low, `spi_sdata` is sampled on each rising edge of `spi_sclk`. The first 8 bits form the address, sent bit 7 first. The next 16 bits form the data, sent bit 15 first.
- R3: The write is committed on the 24th rising edge of a select window. Any further bits in the same window, whatever their value, change nothing.
- R4: Raising `spi_csn` before 24 bits have been sent discards the partial frame. The next frame is counted from its first bit.
- R5: Writing address 0x00 with data bit 0 = 1 returns every field to zero. Writing address 0x00 with data bit 0 = 0 changes nothing. No reset state remains afterwards, so the following frame writes normally.
- R6: Address 0x0F holds the power fields. Data bits 7:0 are `chan_sleep` (bit n = channel n). Bit 8 is `deep_sleep`. Bit 9 is `power_down`. Bits 11:10 are `pd_pin_mode`. Writing 0x0200 and then 0x0000 raises `power_down` and then clears it.
- R7: Address 0x24 bits 7:0 are `invert_ch`. Address 0x25 bits 2:0 are `pat_sel`. Address 0x26 bits 13:0 are `pat_code_a`. Address 0x27 bits 13:0 are `pat_code_b`. Address 0x46 bit 0 is `twos_comp` and bit 1 is `msb_first`. Data bits outside these fields are dropped.
- R8: A write to any address other than 0x00, 0x0F, 0x24, 0x25, 0x26, 0x27 or 0x46 changes no field.
- R9: A committed value reaches the outputs through two `sys_clk` flip-flops. The output still holds the old value after the first `sys_clk` rising edge that follows the write, and shows the new value after the second.
- R10: If `spi_csn` is raised while `spi_sclk` is still high after the 24th rising edge, the write still lands. The next frame then starts cleanly from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock that the outputs are synchronized to |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| spi_csn | input | 1 | Active-low select; a high level clears the frame tracker |
| spi_sclk | input | 1 | Serial clock; data is sampled on the rising edge |
| spi_sdata | input | 1 | Serial data in |
| chan_sleep | output | 8 | Per-channel light-sleep requests |
| deep_sleep | output | 1 | All-channel deep sleep request |
| power_down | output | 1 | Full power-down request |
| pd_pin_mode | output | 2 | Selects what the external power-down pin does |
| invert_ch | output | 8 | Per-channel input polarity swap |
| pat_sel | output | 3 | Test-pattern selector |
| pat_code_a | output | 14 | First custom pattern code |
| pat_code_b | output | 14 | Second custom pattern code |
| twos_comp | output | 1 | Two's complement output format |
| msb_first | output | 1 | Serial output order, MSB first when high |

## Verification
Committing a frame and releasing the select line can fall into the same serial-clock period. The 24th rising edge writes the register file while the frame tracker is being cleared asynchronously. The bench provokes this by raising `spi_csn` a few nanoseconds after the 24th rising edge, while the serial clock is still high. It judges the result in two ways: the pattern code written by that frame must appear at the outputs, and a frame sent immediately afterwards must land at its own address with its own data, which shows that the counter started again from zero.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int FRAME_W = 24;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = FRAME_W - ADDR_W;
    localparam int NUM_CH  = 8;
    localparam int CODE_W  = 14;
    localparam int PAT_W   = 3;
    localparam int PINM_W  = 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    localparam logic [ADDR_W-1:0] A_SWRST  = 8'h00;
    localparam logic [ADDR_W-1:0] A_POWER  = 8'h0F;
    localparam logic [ADDR_W-1:0] A_INVERT = 8'h24;
    localparam logic [ADDR_W-1:0] A_PATSEL = 8'h25;
    localparam logic [ADDR_W-1:0] A_CODEA  = 8'h26;
    localparam logic [ADDR_W-1:0] A_CODEB  = 8'h27;
    localparam logic [ADDR_W-1:0] A_FORMAT = 8'h46;

    localparam int B_SWRST = 0;
    localparam int B_DEEP  = 8;
    localparam int B_PWRDN = 9;
    localparam int B_PINM  = 10;
    localparam int B_TWOS  = 0;
    localparam int B_MSBF  = 1;

    typedef enum logic [1:0] {
        S_ADDR = 2'd0,
        S_DATA = 2'd1,
        S_SKIP = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic [NUM_CH-1:0] chan_sleep;
        logic              deep_sleep;
        logic              power_down;
        logic [PINM_W-1:0] pd_pin_mode;
        logic [NUM_CH-1:0] invert_ch;
        logic [PAT_W-1:0]  pat_sel;
        logic [CODE_W-1:0] pat_code_a;
        logic [CODE_W-1:0] pat_code_b;
        logic              twos_comp;
        logic              msb_first;
    } cfg_t;

    localparam int   CFG_W       = $bits(cfg_t);
    localparam cfg_t CFG_DEFAULT = '0;

    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        return a inside {A_SWRST, A_POWER, A_INVERT, A_PATSEL,
                         A_CODEA, A_CODEB, A_FORMAT};
    endfunction

endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spi_cfg_pkg::*;
(
    input  logic              sclk,
    input  logic              frm_rst_n,
    input  logic              sdata,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_W - 1);

    rx_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [FRAME_W-2:0] sh_q, sh_d;
    logic               done_q;
    logic [FRAME_W-1:0] word;

    assign word    = {sh_q, sdata};
    assign wr_addr = word[FRAME_W-1 -: ADDR_W];
    assign wr_data = word[DATA_W-1:0];

    // state register, cleared whenever select is high
    always_ff @(posedge sclk or negedge frm_rst_n) begin
        if (!frm_rst_n) begin
            state_q <= S_ADDR;
            cnt_q   <= '0;
            sh_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            done_q  <= done_q | wr_stb;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        wr_stb  = 1'b0;
        unique case (state_q)
            S_ADDR: begin
                sh_d  = {sh_q[FRAME_W-3:0], sdata};
                cnt_d = cnt_q + CNT_W'(1);
                if (cnt_q == ADDR_LAST) begin
                    state_d = S_DATA;
                end
            end
            S_DATA: begin
                sh_d  = {sh_q[FRAME_W-3:0], sdata};
                cnt_d = cnt_q + CNT_W'(1);
                if (cnt_q == FRAME_LAST) begin
                    wr_stb  = 1'b1;
                    cnt_d   = cnt_q;
                    state_d = S_SKIP;
                end
            end
            S_SKIP: begin
                state_d = S_SKIP;
            end
            default: begin
                state_d = S_ADDR;
            end
        endcase
    end

    // R2
    addr_phase_cnt_chk: assert property (@(posedge sclk) disable iff (!frm_rst_n)
        (state_q == S_ADDR) |-> (cnt_q < CNT_W'(ADDR_W)));

    // R2
    data_phase_cnt_chk: assert property (@(posedge sclk) disable iff (!frm_rst_n)
        (state_q == S_DATA) |-> ((cnt_q >= CNT_W'(ADDR_W)) && (cnt_q <= FRAME_LAST)));

    // R3
    single_write_chk: assert property (@(posedge sclk) disable iff (!frm_rst_n)
        wr_stb |-> !done_q);

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
    import spi_cfg_pkg::*;
(
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg_q
);

    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_stb) begin
            unique case (wr_addr)
                A_SWRST: begin
                    if (wr_data[B_SWRST]) begin
                        cfg_d = CFG_DEFAULT;
                    end
                end
                A_POWER: begin
                    cfg_d.chan_sleep  = wr_data[NUM_CH-1:0];
                    cfg_d.deep_sleep  = wr_data[B_DEEP];
                    cfg_d.power_down  = wr_data[B_PWRDN];
                    cfg_d.pd_pin_mode = wr_data[B_PINM +: PINM_W];
                end
                A_INVERT: cfg_d.invert_ch  = wr_data[NUM_CH-1:0];
                A_PATSEL: cfg_d.pat_sel    = wr_data[PAT_W-1:0];
                A_CODEA:  cfg_d.pat_code_a = wr_data[CODE_W-1:0];
                A_CODEB:  cfg_d.pat_code_b = wr_data[CODE_W-1:0];
                A_FORMAT: begin
                    cfg_d.twos_comp = wr_data[B_TWOS];
                    cfg_d.msb_first = wr_data[B_MSBF];
                end
                default: begin
                    cfg_d = cfg_q;
                end
            endcase
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_DEFAULT;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // R5
    swrst_restore_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (wr_stb && (wr_addr == A_SWRST) && wr_data[B_SWRST]) |=> (cfg_q == CFG_DEFAULT));

    // R8
    unmapped_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (wr_stb && !is_mapped(wr_addr)) |=> $stable(cfg_q));

endmodule

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int               WIDTH     = 8,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RESET_VAL;
                else        stg_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RESET_VAL;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              sys_clk,
    input  logic              rst_n,
    input  logic              spi_csn,
    input  logic              spi_sclk,
    input  logic              spi_sdata,
    output logic [NUM_CH-1:0] chan_sleep,
    output logic              deep_sleep,
    output logic              power_down,
    output logic [PINM_W-1:0] pd_pin_mode,
    output logic [NUM_CH-1:0] invert_ch,
    output logic [PAT_W-1:0]  pat_sel,
    output logic [CODE_W-1:0] pat_code_a,
    output logic [CODE_W-1:0] pat_code_b,
    output logic              twos_comp,
    output logic              msb_first
);

    logic              frm_rst_n;
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    cfg_t              cfg_sclk;
    cfg_t              cfg_sys;
    logic [CFG_W-1:0]  sync_out;

    assign frm_rst_n = rst_n & ~spi_csn;

    spi_frame_rx u_rx (
        .sclk      (spi_sclk),
        .frm_rst_n (frm_rst_n),
        .sdata     (spi_sdata),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    spi_cfg_regs u_regs (
        .sclk    (spi_sclk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_q   (cfg_sclk)
    );

    cfg_sync #(
        .WIDTH     (CFG_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (CFG_DEFAULT)
    ) u_sync (
        .clk   (sys_clk),
        .rst_n (rst_n),
        .d     (cfg_sclk),
        .q     (sync_out)
    );

    assign cfg_sys     = cfg_t'(sync_out);
    assign chan_sleep  = cfg_sys.chan_sleep;
    assign deep_sleep  = cfg_sys.deep_sleep;
    assign power_down  = cfg_sys.power_down;
    assign pd_pin_mode = cfg_sys.pd_pin_mode;
    assign invert_ch   = cfg_sys.invert_ch;
    assign pat_sel     = cfg_sys.pat_sel;
    assign pat_code_a  = cfg_sys.pat_code_a;
    assign pat_code_b  = cfg_sys.pat_code_b;
    assign twos_comp   = cfg_sys.twos_comp;
    assign msb_first   = cfg_sys.msb_first;

endmodule

// File: tb/tb_spi_cfg_slave.sv
module tb_spi_cfg_slave;
    import spi_cfg_pkg::*;

    logic sys_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic csn     = 1'b1;
    logic sclk    = 1'b0;
    logic sdata   = 1'b0;

    logic [NUM_CH-1:0] chan_sleep, invert_ch;
    logic              deep_sleep, power_down, twos_comp, msb_first;
    logic [PINM_W-1:0] pd_pin_mode;
    logic [PAT_W-1:0]  pat_sel;
    logic [CODE_W-1:0] pat_code_a, pat_code_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 sys_clk = ~sys_clk;

    spi_cfg_slave dut (
        .sys_clk     (sys_clk),
        .rst_n       (rst_n),
        .spi_csn     (csn),
        .spi_sclk    (sclk),
        .spi_sdata   (sdata),
        .chan_sleep  (chan_sleep),
        .deep_sleep  (deep_sleep),
        .power_down  (power_down),
        .pd_pin_mode (pd_pin_mode),
        .invert_ch   (invert_ch),
        .pat_sel     (pat_sel),
        .pat_code_a  (pat_code_a),
        .pat_code_b  (pat_code_b),
        .twos_comp   (twos_comp),
        .msb_first   (msb_first)
    );

    // {frame[23:0], field id[3:0], expected[15:0]}
    localparam int NV = 15;
    localparam logic [43:0] VEC [NV] = '{
        {24'h0F00A5, 4'd0, 16'h00A5},
        {24'h0F0200, 4'd2, 16'h0001},
        {24'h0F0000, 4'd2, 16'h0000},
        {24'h0F0C00, 4'd3, 16'h0003},
        {24'h0F0100, 4'd1, 16'h0001},
        {24'h24FF3C, 4'd4, 16'h003C},
        {24'h25FFFD, 4'd5, 16'h0005},
        {24'h26FFFF, 4'd6, 16'h3FFF},
        {24'h271234, 4'd7, 16'h1234},
        {24'h460002, 4'd9, 16'h0001},
        {24'h460001, 4'd8, 16'h0001},
        {24'h460003, 4'd9, 16'h0001},
        {24'h13FFFF, 4'd7, 16'h1234},
        {24'h2A5555, 4'd6, 16'h3FFF},
        {24'h262AAA, 4'd6, 16'h2AAA}
    };

    function automatic logic [15:0] field(input int id);
        case (id)
            0: return 16'(chan_sleep);
            1: return 16'(deep_sleep);
            2: return 16'(power_down);
            3: return 16'(pd_pin_mode);
            4: return 16'(invert_ch);
            5: return 16'(pat_sel);
            6: return 16'(pat_code_a);
            7: return 16'(pat_code_b);
            8: return 16'(twos_comp);
            default: return 16'(msb_first);
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all_zero(input string req);
        for (int f = 0; f < 10; f++) check(req, field(f), 16'h0000);
    endtask

    task automatic send(input logic [23:0] fr, input int nbits, input bit probe,
                        input logic [15:0] old_v, input logic [15:0] new_v, input bit early);
        @(negedge sys_clk);
        csn   = 1'b0;
        sdata = fr[23];
        for (int i = 0; i < nbits; i++) begin
            @(negedge sys_clk);
            sclk = 1'b1;
            if (i == 23 && probe) begin
                @(posedge sys_clk); #2;
                check("R9 first edge", 16'(invert_ch), old_v);
                @(posedge sys_clk); #2;
                check("R9 second edge", 16'(invert_ch), new_v);
            end
            if (i == 23 && early) begin
                #3 csn = 1'b1;
            end
            @(negedge sys_clk);
            sclk  = 1'b0;
            sdata = (i + 1 < 24) ? fr[22 - i] : 1'b1;
        end
        @(negedge sys_clk);
        csn   = 1'b1;
        sdata = 1'b0;
        repeat (4) @(negedge sys_clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge sys_clk);
        // R1 reset state
        check_all_zero("R1 reset state");
        rst_n = 1'b1;
        repeat (2) @(negedge sys_clk);

        // table walk: R6 power fields, R7 other fields, R8 unmapped
        for (int v = 0; v < NV; v++) begin
            logic [23:0] fr;
            int          id;
            fr = VEC[v][43:20];
            id = int'(VEC[v][19:16]);
            send(fr, 24, 1'b0, 16'h0, 16'h0, 1'b0);
            if (!is_mapped(fr[23:16]))
                check("R8 unmapped", field(id), VEC[v][15:0]);
            else if (id <= 3)
                check("R6 power field", field(id), VEC[v][15:0]);
            else
                check("R7 field", field(id), VEC[v][15:0]);
        end

        // R2 MSB-first ordering
        send(24'h270001, 24, 1'b0, 16'h0, 16'h0, 1'b0);
        check("R2 bit order", 16'(pat_code_b), 16'h0001);

        // R4 short frame discarded, next frame counted afresh
        send(24'h2400FF, 16, 1'b0, 16'h0, 16'h0, 1'b0);
        check("R4 short frame", 16'(invert_ch), 16'h003C);
        send(24'h240011, 24, 1'b0, 16'h0, 16'h0, 1'b0);
        check("R4 fresh frame", 16'(invert_ch), 16'h0011);

        // R3 over-length window, R9 synchronizer latency
        send(24'h240042, 32, 1'b1, 16'h0011, 16'h0042, 1'b0);
        check("R3 trailing bits", 16'(invert_ch), 16'h0042);

        // R10 select released in the 24th high phase
        send(24'h273ABC, 24, 1'b0, 16'h0, 16'h0, 1'b1);
        check("R10 early release", 16'(pat_code_b), 16'h3ABC);
        send(24'h260155, 24, 1'b0, 16'h0, 16'h0, 1'b0);
        check("R10 next frame", 16'(pat_code_a), 16'h0155);

        // R5 software reset
        send(24'h000000, 24, 1'b0, 16'h0, 16'h0, 1'b0);
        check("R5 bit clear no effect", 16'(invert_ch), 16'h0042);
        send(24'h000001, 24, 1'b0, 16'h0, 16'h0, 1'b0);
        check_all_zero("R5 soft reset");
        send(24'h240007, 24, 1'b0, 16'h0, 16'h0, 1'b0);
        check("R5 write after soft reset", 16'(invert_ch), 16'h0007);

        // R1 asynchronous reset pulse
        send(24'h240055, 24, 1'b0, 16'h0, 16'h0, 1'b0);
        check("R1 pre-pulse", 16'(invert_ch), 16'h0055);
        @(negedge sys_clk);
        rst_n = 1'b0;
        #20 rst_n = 1'b1;
        repeat (3) @(negedge sys_clk);
        check("R1 reset pulse", 16'(invert_ch), 16'h0000);

        finish_run();
    end

endmodule